// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Unit

This unit sits between the interrupt request lines of a processor core and its exception sequencer. Peripherals present a 3-bit encoded priority level. The unit compares that level with the interrupt mask held in a small status register, but only at a bus-cycle boundary. When it accepts a request it enters an acknowledge phase and drives the function code to all ones. The acknowledge phase ends when the interrupting device answers. The device either supplies its own vector number or asks for an automatic vector derived from the level.

When the answer arrives, the unit emits a one-cycle "take interrupt" pulse that carries the vector. In the same cycle it saves the old status into a single-entry slot, raises the mask to the accepted level, enters supervisor state and turns tracing off. A return strobe copies the saved slot back into the status register. Software can also write the status register directly.

Top module: `irq_level_accept`

## Requirements
- R1: After reset the mask is 7, supervisor is 1, trace is 0, the function code is 000 and the take pulse is low.
- R2: A nonzero level is accepted when it is strictly greater than the mask, or when it is 7, whatever the mask is. Acceptance shows as function code 111 in the cycle after the boundary.
- R3: Level 0 is never accepted, and a nonzero level that is not above the mask (other than 7) leaves the function code at 000.
- R4: The level is sampled only on a cycle where the bus-cycle-end input is high. A request without that strobe is not accepted.
- R5: The level is captured once at acceptance. Changes on the request lines during the acknowledge phase do not alter the vector or the new mask.
- R6: When the device answers with the autovector input high, the vector is 24 plus the accepted level (25 to 31). Otherwise the vector is the 8-bit value the device supplies.
- R7: The answer ends the acknowledge phase. In the next cycle the function code returns to 000, take is high for exactly one cycle with the vector, the mask equals the accepted level, supervisor is 1 and trace is 0.
- R8: A return strobe restores the status (mask, supervisor, trace) that was current just before the last acceptance.
- R9: The save slot holds one entry. A nested acceptance overwrites it, so a later return restores the status of the first handler.
- R10: A status write loads the status input, with bit 4 = supervisor, bit 3 = trace and bits 2:0 = mask. A completing acceptance takes precedence over a return, and a return takes precedence over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ipl | input | 3 | Encoded request level, 0 = none |
| cycle_end | input | 1 | Current bus cycle finishes this clock |
| vec_ack | input | 1 | Device answer ending the acknowledge phase |
| vec_auto | input | 1 | Device asks for an automatic vector |
| vec_data | input | 8 | Device-supplied vector number |
| rte | input | 1 | Return strobe, restores saved status |
| sr_load | input | 1 | Status register write strobe |
| sr_in | input | 5 | Status write data {supervisor, trace, mask} |
| fc | output | 3 | Function code, 111 during acknowledge |
| take | output | 1 | One-cycle take-interrupt pulse |
| take_vec | output | 8 | Vector number valid with take |
| sr_mask | output | 3 | Current mask level |
| sr_super | output | 1 | Supervisor bit |
| sr_trace | output | 1 | Trace bit |

## Verification
Some properties are checked on every cycle: the acceptance rule against the mask at the moment the acknowledge phase opens, that it opens only on a boundary, that the acknowledge phase is held until the answer, that take lasts one cycle, and the status and autovector values that come with take. The bench sweeps every mask and level pair. For each accepted case it shows that the vector and the new mask come from the captured level and not from the live lines. What only the bench scenarios show is the restore path: that a return brings back the earlier status, and that a nested acceptance overwrites the single save slot.

// File: rtl/irq_level_accept.sv
module irq_level_accept #(
  parameter int LW = 3,
  parameter int VW = 8,
  parameter int AUTO_BASE = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] ipl,
  input  logic          cycle_end,
  input  logic          vec_ack,
  input  logic          vec_auto,
  input  logic [VW-1:0] vec_data,
  input  logic          rte,
  input  logic          sr_load,
  input  logic [LW+1:0] sr_in,
  output logic [LW-1:0] fc,
  output logic          take,
  output logic [VW-1:0] take_vec,
  output logic [LW-1:0] sr_mask,
  output logic          sr_super,
  output logic          sr_trace
);
  localparam logic [LW-1:0] TOP = '1;

  logic          ack_q;
  logic [LW-1:0] lvl_q;
  logic [LW+1:0] saved;

  wire hit  = cycle_end && !ack_q && (ipl != '0) && ((ipl > sr_mask) || (ipl == TOP));
  wire done = ack_q && vec_ack;

  assign fc = ack_q ? TOP : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      lvl_q    <= '0;
      take     <= 1'b0;
      take_vec <= '0;
      sr_mask  <= TOP;
      sr_super <= 1'b1;
      sr_trace <= 1'b0;
      saved    <= {1'b1, 1'b0, TOP};
    end else begin
      take <= done;
      if (hit) begin
        ack_q <= 1'b1;
        lvl_q <= ipl;
      end
      if (done) begin
        ack_q    <= 1'b0;
        take_vec <= vec_auto ? VW'(AUTO_BASE) + VW'(lvl_q) : vec_data;
        saved    <= {sr_super, sr_trace, sr_mask};
        sr_mask  <= lvl_q;
        sr_super <= 1'b1;
        sr_trace <= 1'b0;
      end else if (rte) begin
        {sr_super, sr_trace, sr_mask} <= saved;
      end else if (sr_load) begin
        {sr_super, sr_trace, sr_mask} <= sr_in;
      end
    end
  end
endmodule

module irq_level_accept_chk #(
  parameter int LW = 3,
  parameter int VW = 8,
  parameter int AUTO_BASE = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] ipl,
  input logic          cycle_end,
  input logic          vec_ack,
  input logic          vec_auto,
  input logic [LW-1:0] fc,
  input logic          take,
  input logic [VW-1:0] take_vec,
  input logic [LW-1:0] sr_mask,
  input logic          sr_super,
  input logic          sr_trace
);
  localparam logic [LW-1:0] TOP = '1;

  p_accept_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fc == TOP) |-> ($past(ipl) != '0) && (($past(ipl) > $past(sr_mask)) || ($past(ipl) == TOP)));

  p_boundary_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fc == TOP) |-> $past(cycle_end));

  p_hold_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == TOP) && !vec_ack |=> (fc == TOP));

  p_take_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  p_take_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> sr_super && !sr_trace && (fc == '0));

  p_autovec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && $past(vec_auto) |-> take_vec == VW'(AUTO_BASE) + VW'(sr_mask));
endmodule

bind irq_level_accept irq_level_accept_chk #(.LW(LW), .VW(VW), .AUTO_BASE(AUTO_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ipl(ipl), .cycle_end(cycle_end), .vec_ack(vec_ack),
  .vec_auto(vec_auto), .fc(fc), .take(take), .take_vec(take_vec),
  .sr_mask(sr_mask), .sr_super(sr_super), .sr_trace(sr_trace));

// File: tb/test_irq_level_accept.sv
module test_irq_level_accept;
  logic clk = 0, rst_n = 0;
  logic [2:0] ipl = 0;
  logic cycle_end = 0, vec_ack = 0, vec_auto = 0, rte = 0, sr_load = 0;
  logic [7:0] vec_data = 0;
  logic [4:0] sr_in = 0;
  logic [2:0] fc, sr_mask;
  logic take, sr_super, sr_trace;
  logic [7:0] take_vec;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_level_accept i_irq_level_accept (
    .clk(clk), .rst_n(rst_n), .ipl(ipl), .cycle_end(cycle_end), .vec_ack(vec_ack),
    .vec_auto(vec_auto), .vec_data(vec_data), .rte(rte), .sr_load(sr_load), .sr_in(sr_in),
    .fc(fc), .take(take), .take_vec(take_vec), .sr_mask(sr_mask),
    .sr_super(sr_super), .sr_trace(sr_trace));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_sr(input logic s, input logic t, input logic [2:0] m);
    sr_load = 1; sr_in = {s, t, m};
    step();
    sr_load = 0;
  endtask

  task automatic accept(input logic [2:0] l, input logic au);
    ipl = l; cycle_end = 1;
    step();
    cycle_end = 0; ipl = ~l;
    chk(fc == 3'b111, "R2 ack code", fc, 7);
    vec_auto = au; vec_data = 8'h40 + 8'(l) * 3; vec_ack = 1;
    step();
    vec_ack = 0; ipl = 0;
    chk(take == 1, "R7 take high", take, 1);
    chk(take_vec == (au ? 8'(24 + l) : 8'h40 + 8'(l) * 3), "R6 vector", take_vec,
        au ? 24 + l : 64 + l * 3);
    chk(sr_mask == l, "R5 mask from captured level", sr_mask, l);
    chk(sr_super == 1 && sr_trace == 0, "R7 S/T after take", {sr_super, sr_trace}, 2);
    chk(fc == 0, "R7 fc idle", fc, 0);
    step();
    chk(take == 0, "R7 take one cycle", take, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(sr_mask == 7 && sr_super == 1 && sr_trace == 0, "R1 status reset",
        {sr_super, sr_trace, sr_mask}, 5'b10111);
    chk(fc == 0 && take == 0, "R1 fc/take reset", {fc, take}, 0);
    rst_n = 1;
    step();
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        bit acc;
        acc = (l != 0) && (l > m || l == 7);
        load_sr(0, 1, 3'(m));
        chk(sr_mask == m && sr_super == 0 && sr_trace == 1, "R10 status write",
            {sr_super, sr_trace, sr_mask}, {2'b01, 3'(m)});
        if (acc) begin
          accept(3'(l), l[0]);
          rte = 1;
          step();
          rte = 0;
          chk(sr_mask == m && sr_super == 0 && sr_trace == 1, "R8 restore",
              {sr_super, sr_trace, sr_mask}, {2'b01, 3'(m)});
        end else begin
          ipl = 3'(l); cycle_end = 1;
          step();
          cycle_end = 0; ipl = 0;
          chk(fc == 0, "R3 rejected", fc, 0);
        end
      end
    end
    load_sr(0, 0, 0);
    ipl = 4;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(fc == 0, "R4 no boundary", fc, 0);
    end
    ipl = 0;
    load_sr(0, 1, 1);
    accept(3, 1);
    accept(5, 0);
    rte = 1;
    step();
    rte = 0;
    chk(sr_mask == 3 && sr_super == 1 && sr_trace == 0, "R9 nested overwrite",
        {sr_super, sr_trace, sr_mask}, 5'b10011);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule